// File: doc/BRIEF.md
# Cache Block Invalidate Controller

This block carries out a privileged invalidate of one data-cache block. It holds a small MEI tag/state array and accepts one request at a time. Each request carries a block address and three flags from the translation stage: a block-translation protection violation, a page-translation protection violation and a direct-store segment marker. It also sees a configuration bit that enables address broadcast.

A request that passes its checks moves a matching line to Invalid. A Modified line is also dropped and is never written back. When broadcast is enabled, the block then issues an address-only invalidate on the bus through a valid/ready handshake. A protection failure reports a data-storage exception with a cause code. A request that targets a direct-store segment completes with no effect.

The array is filled through a simple install port, and its contents can be read through a combinational probe port. Cache-disable and cache-lock controls gate installs only. They never block an invalidate.

Top module: `cbi_unit`

## Requirements
- R1: While reset is asserted and right after it, `req_ready_o` is 1, `bus_valid_o` and `done_o` are 0, and every line is Invalid, so `probe_state_o` reads 2'b00 for any block.
- R2: A request that is accepted, has no fault and hits a line in state E (2'b01) or M (2'b11) leaves that line Invalid (2'b00) from the next cycle on. Other lines are unaffected, and no data is moved.
- R3: After a fault-free request is accepted, `bus_valid_o` rises in the next cycle exactly when `bcast_en_i` was 1 at acceptance, whether the lookup hit or missed. With `bcast_en_i` at 0 there is no bus request at all.
- R4: While `bus_valid_o` is 1 and `bus_ready_i` is 0, `bus_valid_o` stays 1 and `bus_blk_o` stays equal to the request's block address. `done_o` pulses for one cycle in the cycle after the handshake completes.
- R5: A request that needs no broadcast (fault, direct-store or broadcast disabled) pulses `done_o` in the cycle right after acceptance.
- R6: With `cache_en_i` = 0 or `cache_lock_i` = 1, installs are ignored, but invalidate requests still take effect.
- R7: A request with `bat_viol_i` = 1 and no direct-store flag reports `dsi_o` = 1 with `dsi_cause_o` = 2'b01 together with `done_o`, even if `tlb_viol_i` is also 1. The line state is left unchanged and there is no broadcast.
- R8: A request with only `tlb_viol_i` = 1 reports `dsi_o` = 1 with `dsi_cause_o` = 2'b10, leaves state unchanged and issues no broadcast. Without a fault, `dsi_cause_o` is 2'b00.
- R9: A request with `direct_store_i` = 1 is a no-op whatever the other flags: it gives `done_o` only, with no exception, no state change and no broadcast.
- R10: `req_ready_o` is 0 while a broadcast is outstanding, and `req_valid_i` is ignored in that time.
- R11: `fill_valid_i` writes tag and state `fill_state_i` into way `fill_way_i` of the set given by the low 4 bits of `fill_blk_i`. `probe_state_o` returns the state of the valid way whose tag matches `probe_blk_i`, or 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Invalidate request |
| req_ready_o | output | 1 | Block can accept a request |
| req_blk_i | input | 27 | Block address of the request |
| bat_viol_i | input | 1 | Block-translation protection violation |
| tlb_viol_i | input | 1 | Page-translation protection violation |
| direct_store_i | input | 1 | Address lies in a direct-store segment |
| bcast_en_i | input | 1 | Configuration: broadcast invalidates on the bus |
| cache_en_i | input | 1 | Cache enabled (gates installs) |
| cache_lock_i | input | 1 | Cache locked (blocks installs) |
| fill_valid_i | input | 1 | Install a line |
| fill_blk_i | input | 27 | Block address to install |
| fill_way_i | input | 2 | Way to install into |
| fill_state_i | input | 2 | MEI state to install |
| probe_blk_i | input | 27 | Block address to look up |
| probe_state_o | output | 2 | State of the matching line, 2'b00 if none |
| bus_valid_o | output | 1 | Address-only invalidate on the bus |
| bus_ready_i | input | 1 | Bus accepts the invalidate |
| bus_blk_o | output | 27 | Block address on the bus |
| done_o | output | 1 | Request complete, one-cycle pulse |
| dsi_o | output | 1 | Data-storage exception, valid with done_o |
| dsi_cause_o | output | 2 | 01 block-translation, 10 page-translation, 00 none |

## Verification
The bench sets both violation flags together. A design with the priority reversed would report cause 2'b10 where 2'b01 is due. It also sends a direct-store request with a violation flag set, which a design that checks protection before the segment type would turn into an exception. Modified lines are invalidated with broadcast both off and on, and misses are sent with broadcast on. A design that skips the bus on a miss, or that makes Modified lines wait for a writeback, shows up as a wrong `bus_valid_o` or a line left valid. Requests are held during a stalled handshake and sent with the cache disabled and locked, which exposes a design that accepts a second request early or lets the disable or lock controls block an invalidate.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_E = 2'b01,
    ST_M = 2'b11
  } mei_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_BLOCK = 2'b01,
    CAUSE_PAGE  = 2'b10
  } cause_e;

  typedef enum logic {
    CTL_IDLE  = 1'b0,
    CTL_BCAST = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cbi_tag_array.sv
module cbi_tag_array
  import cbi_pkg::*;
#(
  parameter int BLK_W = 27,
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = BLK_W - IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] lk_blk_i,
  output logic             lk_hit_o,
  output logic [WAY_W-1:0] lk_way_o,
  input  logic [BLK_W-1:0] probe_blk_i,
  output logic [1:0]       probe_state_o,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [WAY_W-1:0] inv_way_i,
  input  logic             fill_en_i,
  input  logic [BLK_W-1:0] fill_blk_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [1:0]       fill_state_i
);
  mei_e             st_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_idx, pr_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, pr_tag;
  logic [WAYS-1:0]  lk_match, pr_match;

  assign lk_idx = lk_blk_i[IDX_W-1:0];
  assign lk_tag = lk_blk_i[BLK_W-1:IDX_W];
  assign pr_idx = probe_blk_i[IDX_W-1:0];
  assign pr_tag = probe_blk_i[BLK_W-1:IDX_W];
  assign fl_idx = fill_blk_i[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_match[w] = (st_q[lk_idx][w] != ST_I) && (tag_q[lk_idx][w] == lk_tag);
    assign pr_match[w] = (st_q[pr_idx][w] != ST_I) && (tag_q[pr_idx][w] == pr_tag);
  end

  assign lk_hit_o = |lk_match;

  always_comb begin
    lk_way_o      = '0;
    probe_state_o = ST_I;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) lk_way_o = WAY_W'(w);
      if (pr_match[w]) probe_state_o = st_q[pr_idx][w];
    end
  end

  // invalidate is applied last so it wins on the same line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          st_q[s][w] <= ST_I;
    end else begin
      if (fill_en_i) st_q[fl_idx][fill_way_i] <= mei_e'(fill_state_i);
      if (inv_en_i)  st_q[inv_idx_i][inv_way_i] <= ST_I;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fl_idx][fill_way_i] <= fill_blk_i[BLK_W-1:IDX_W];
  end
endmodule

// File: rtl/cbi_ctrl.sv
module cbi_ctrl
  import cbi_pkg::*;
#(
  parameter int BLK_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             bat_viol_i,
  input  logic             tlb_viol_i,
  input  logic             direct_store_i,
  input  logic             bcast_en_i,
  input  logic             lk_hit_i,
  output logic             inv_en_o,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic [BLK_W-1:0] bus_blk_o,
  output logic             done_o,
  output logic             dsi_o,
  output logic [1:0]       dsi_cause_o
);
  ctl_state_e       state_q;
  logic [BLK_W-1:0] blk_q;
  logic             done_q, dsi_q;
  cause_e           cause_q;

  logic accept, clean, fault_blk, fault_pg, need_bus;

  assign accept    = req_valid_i && (state_q == CTL_IDLE);
  // direct-store outranks protection; block fault outranks page fault
  assign fault_blk = !direct_store_i && bat_viol_i;
  assign fault_pg  = !direct_store_i && !bat_viol_i && tlb_viol_i;
  assign clean     = !direct_store_i && !bat_viol_i && !tlb_viol_i;
  assign need_bus  = clean && bcast_en_i;
  assign inv_en_o  = accept && clean && lk_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CTL_IDLE;
      blk_q   <= '0;
      done_q  <= 1'b0;
      dsi_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      done_q  <= 1'b0;
      dsi_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      case (state_q)
        CTL_IDLE: if (accept) begin
          if (need_bus) begin
            state_q <= CTL_BCAST;
            blk_q   <= req_blk_i;
          end else begin
            done_q <= 1'b1;
          end
          dsi_q <= fault_blk || fault_pg;
          if (fault_blk)     cause_q <= CAUSE_BLOCK;
          else if (fault_pg) cause_q <= CAUSE_PAGE;
        end
        CTL_BCAST: if (bus_ready_i) begin
          state_q <= CTL_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= CTL_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == CTL_IDLE);
  assign bus_valid_o = (state_q == CTL_BCAST);
  assign bus_blk_o   = blk_q;
  assign done_o      = done_q;
  assign dsi_o       = dsi_q;
  assign dsi_cause_o = cause_q;
endmodule

// File: rtl/cbi_unit.sv
module cbi_unit
  import cbi_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32,
  parameter int WAYS      = 4,
  parameter int SETS      = 16,
  localparam int OFF_W = $clog2(BLK_BYTES),
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             bat_viol_i,
  input  logic             tlb_viol_i,
  input  logic             direct_store_i,
  input  logic             bcast_en_i,
  input  logic             cache_en_i,
  input  logic             cache_lock_i,
  input  logic             fill_valid_i,
  input  logic [BLK_W-1:0] fill_blk_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [1:0]       fill_state_i,
  input  logic [BLK_W-1:0] probe_blk_i,
  output logic [1:0]       probe_state_o,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic [BLK_W-1:0] bus_blk_o,
  output logic             done_o,
  output logic             dsi_o,
  output logic [1:0]       dsi_cause_o
);
  logic             lk_hit, inv_en, fill_en;
  logic [WAY_W-1:0] lk_way;

  // disable and lock stop allocation only, never invalidation
  assign fill_en = fill_valid_i && cache_en_i && !cache_lock_i;

  cbi_tag_array #(.BLK_W(BLK_W), .WAYS(WAYS), .SETS(SETS)) u_tags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lk_blk_i      (req_blk_i),
    .lk_hit_o      (lk_hit),
    .lk_way_o      (lk_way),
    .probe_blk_i   (probe_blk_i),
    .probe_state_o (probe_state_o),
    .inv_en_i      (inv_en),
    .inv_idx_i     (req_blk_i[IDX_W-1:0]),
    .inv_way_i     (lk_way),
    .fill_en_i     (fill_en),
    .fill_blk_i    (fill_blk_i),
    .fill_way_i    (fill_way_i),
    .fill_state_i  (fill_state_i)
  );

  cbi_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_blk_i      (req_blk_i),
    .bat_viol_i     (bat_viol_i),
    .tlb_viol_i     (tlb_viol_i),
    .direct_store_i (direct_store_i),
    .bcast_en_i     (bcast_en_i),
    .lk_hit_i       (lk_hit),
    .inv_en_o       (inv_en),
    .bus_valid_o    (bus_valid_o),
    .bus_ready_i    (bus_ready_i),
    .bus_blk_o      (bus_blk_o),
    .done_o         (done_o),
    .dsi_o          (dsi_o),
    .dsi_cause_o    (dsi_cause_o)
  );
endmodule

// File: rtl/cbi_unit_chk.sv
module cbi_unit_chk #(
  parameter int BLK_W = 27
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             bat_viol_i,
  input logic             tlb_viol_i,
  input logic             direct_store_i,
  input logic             bcast_en_i,
  input logic             bus_valid_o,
  input logic             bus_ready_i,
  input logic [BLK_W-1:0] bus_blk_o,
  input logic             done_o,
  input logic             dsi_o,
  input logic [1:0]       dsi_cause_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  p_no_bcast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !bcast_en_i |=> !bus_valid_o);

  p_bcast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && bcast_en_i && !direct_store_i && !bat_viol_i && !tlb_viol_i |=> bus_valid_o);

  p_bus_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_blk_o));

  p_bus_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i |=> done_o && !bus_valid_o);

  p_blk_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !direct_store_i && bat_viol_i |=> done_o && dsi_o && dsi_cause_o == 2'b01 && !bus_valid_o);

  p_pg_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !direct_store_i && !bat_viol_i && tlb_viol_i |=> done_o && dsi_o && dsi_cause_o == 2'b10);

  p_dstore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && direct_store_i |=> done_o && !dsi_o && !bus_valid_o);

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !req_ready_o);

  p_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dsi_cause_o) && (dsi_o == (dsi_cause_o != 2'b00)));
endmodule

bind cbi_unit cbi_unit_chk #(.BLK_W(BLK_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .bat_viol_i     (bat_viol_i),
  .tlb_viol_i     (tlb_viol_i),
  .direct_store_i (direct_store_i),
  .bcast_en_i     (bcast_en_i),
  .bus_valid_o    (bus_valid_o),
  .bus_ready_i    (bus_ready_i),
  .bus_blk_o      (bus_blk_o),
  .done_o         (done_o),
  .dsi_o          (dsi_o),
  .dsi_cause_o    (dsi_cause_o)
);

// File: tb/test_cbi_unit.sv
`timescale 1ns/1ps
module test_cbi_unit;
  localparam int BW = 27;
  localparam int NS = 16;
  localparam int NW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [BW-1:0] req_blk_i = '0;
  logic          bat_viol_i = 1'b0, tlb_viol_i = 1'b0, direct_store_i = 1'b0;
  logic          bcast_en_i = 1'b0;
  logic          cache_en_i = 1'b1, cache_lock_i = 1'b0;
  logic          fill_valid_i = 1'b0;
  logic [BW-1:0] fill_blk_i = '0;
  logic [1:0]    fill_way_i = '0;
  logic [1:0]    fill_state_i = '0;
  logic [BW-1:0] probe_blk_i = '0;
  logic [1:0]    probe_state_o;
  logic          bus_valid_o;
  logic          bus_ready_i = 1'b0;
  logic [BW-1:0] bus_blk_o;
  logic          done_o, dsi_o;
  logic [1:0]    dsi_cause_o;

  always #2 clk_i = ~clk_i;

  cbi_unit i_cbi_unit (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit run_chk = 1'b0;
  int rdy_mode = 0; // 0 pseudo-random, 1 low, 2 high
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model
  logic [1:0]    m_st  [NS][NW];
  logic [BW-5:0] m_tag [NS][NW];
  bit            m_busy, m_done, m_dsi;
  logic [1:0]    m_cause;
  logic [BW-1:0] m_blk;

  function automatic logic [1:0] m_probe(input logic [BW-1:0] b);
    logic [1:0] r = 2'b00;
    for (int w = 0; w < NW; w++)
      if (m_st[b[3:0]][w] != 2'b00 && m_tag[b[3:0]][w] == b[BW-1:4]) r = m_st[b[3:0]][w];
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) m_st[s][w] = 2'b00;
      m_busy = 0; m_done = 0; m_dsi = 0; m_cause = 2'b00; m_blk = '0;
    end else begin
      m_done = 0; m_dsi = 0; m_cause = 2'b00;
      if (m_busy) begin
        if (bus_ready_i) begin m_busy = 0; m_done = 1; end
      end else if (req_valid_i) begin
        if (direct_store_i) m_done = 1;
        else if (bat_viol_i) begin m_done = 1; m_dsi = 1; m_cause = 2'b01; end
        else if (tlb_viol_i) begin m_done = 1; m_dsi = 1; m_cause = 2'b10; end
        else begin
          for (int w = 0; w < NW; w++)
            if (m_st[req_blk_i[3:0]][w] != 2'b00 && m_tag[req_blk_i[3:0]][w] == req_blk_i[BW-1:4])
              m_st[req_blk_i[3:0]][w] = 2'b00;
          if (bcast_en_i) begin m_busy = 1; m_blk = req_blk_i; end
          else m_done = 1;
        end
      end
      if (fill_valid_i && cache_en_i && !cache_lock_i) begin
        m_st[fill_blk_i[3:0]][fill_way_i]  = fill_state_i;
        m_tag[fill_blk_i[3:0]][fill_way_i] = fill_blk_i[BW-1:4];
      end
    end
  end

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && run_chk) begin
      chk("R10 req_ready_o", req_ready_o, !m_busy);
      chk("R3 bus_valid_o", bus_valid_o, m_busy);
      if (m_busy) chk("R4 bus_blk_o", bus_blk_o, m_blk);
      chk("R5 done_o", done_o, m_done);
      chk("R7 dsi_o", dsi_o, m_dsi);
      chk("R8 dsi_cause_o", dsi_cause_o, m_cause);
      chk("R11 probe_state_o", probe_state_o, m_probe(probe_blk_i));
    end
  end

  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      1: bus_ready_i = 1'b0;
      2: bus_ready_i = 1'b1;
      default: bus_ready_i = lfsr[0] & lfsr[2];
    endcase
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic fill(input logic [BW-1:0] b, input logic [1:0] w, input logic [1:0] st);
    @(negedge clk_i);
    fill_valid_i = 1; fill_blk_i = b; fill_way_i = w; fill_state_i = st;
    @(negedge clk_i);
    fill_valid_i = 0;
  endtask

  task automatic send(input logic [BW-1:0] b, input bit bat, input bit tlb, input bit ds, input bit bc);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_blk_i = b; bat_viol_i = bat; tlb_viol_i = tlb;
    direct_store_i = ds; bcast_en_i = bc;
    @(negedge clk_i);
    req_valid_i = 0; bat_viol_i = 0; tlb_viol_i = 0; direct_store_i = 0;
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic probe(input logic [BW-1:0] b, input logic [1:0] exp, input string tag);
    @(negedge clk_i);
    probe_blk_i = b;
    #1;
    chk(tag, probe_state_o, exp);
  endtask

  localparam logic [BW-1:0] LA = {23'h00_0a1, 4'd3};
  localparam logic [BW-1:0] LB = {23'h00_0b2, 4'd3};
  localparam logic [BW-1:0] LC = {23'h00_0c3, 4'd7};
  localparam logic [BW-1:0] LD = {23'h00_0d4, 4'd9};
  localparam logic [BW-1:0] LX = {23'h00_0e5, 4'd2};

  initial begin
    #1;
    chk("R1 reset req_ready_o", req_ready_o, 1);
    chk("R1 reset bus_valid_o", bus_valid_o, 0);
    chk("R1 reset done_o", done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    run_chk = 1;
    probe(LA, 2'b00, "R1 probe after reset");

    fill(LA, 2'd0, 2'b01);
    fill(LB, 2'd1, 2'b11);
    fill(LC, 2'd2, 2'b11);
    fill(LD, 2'd3, 2'b01);
    probe(LB, 2'b11, "R11 install M");
    probe(LA, 2'b01, "R11 install E");

    send(LA, 0, 0, 0, 0);
    probe(LA, 2'b00, "R2 E line invalidated");
    probe(LB, 2'b11, "R2 neighbour untouched");

    send(LB, 0, 0, 0, 1);
    probe(LB, 2'b00, "R2 M line dropped with broadcast");

    send({23'h7ff, 4'd5}, 0, 0, 0, 1); // miss, still broadcast R3
    send({23'h7fe, 4'd5}, 0, 0, 0, 0); // miss, quiet R5

    send(LC, 1, 1, 0, 1);
    probe(LC, 2'b11, "R7 block fault keeps state");
    send(LC, 0, 1, 0, 1);
    probe(LC, 2'b11, "R8 page fault keeps state");
    send(LC, 1, 0, 1, 1);
    probe(LC, 2'b11, "R9 direct-store no-op");

    // R10: requests held during a stalled broadcast are ignored
    rdy_mode = 1;
    fill({23'h111, 4'd1}, 2'd0, 2'b11);
    @(negedge clk_i);
    req_valid_i = 1; req_blk_i = {23'h111, 4'd1}; bcast_en_i = 1;
    @(negedge clk_i);
    req_blk_i = LD;
    repeat (4) @(negedge clk_i);
    chk("R10 busy holds ready low", req_ready_o, 0);
    req_valid_i = 0;
    rdy_mode = 2;
    while (!done_o) @(negedge clk_i);
    probe(LD, 2'b01, "R10 held request ignored");
    rdy_mode = 0;

    // R6: disabled and locked cache
    cache_en_i = 0;
    fill(LX, 2'd0, 2'b01);
    probe(LX, 2'b00, "R6 install ignored when disabled");
    cache_en_i = 1; cache_lock_i = 1;
    fill(LX, 2'd0, 2'b01);
    probe(LX, 2'b00, "R6 install ignored when locked");
    send(LC, 0, 0, 0, 1);
    probe(LC, 2'b00, "R6 invalidate while locked");
    cache_en_i = 0;
    send(LD, 0, 0, 0, 0);
    probe(LD, 2'b00, "R6 invalidate while disabled");
    cache_en_i = 1; cache_lock_i = 0;

    // sweep every set and way with mixed flags
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        fill({23'(s * 8 + w + 100), 4'(s)}, 2'(w), (w % 2) ? 2'b11 : 2'b01);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        send({23'(s * 8 + w + 100), 4'(s)}, (s + w) % 5 == 0, (s + w) % 7 == 1, 0, (s + w) % 2 == 0);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        probe({23'(s * 8 + w + 100), 4'(s)},
              ((s + w) % 5 == 0 || (s + w) % 7 == 1) ? ((w % 2) ? 2'b11 : 2'b01) : 2'b00,
              "R2 sweep final state");

    repeat (4) @(negedge clk_i);
    summary();
  end
endmodule